// File: doc/BRIEF.md
# Beam Position Capture and Byte Readout

This block takes a snapshot of the running horizontal and vertical beam counters (9 bits each) and lets a CPU read each snapshot back through an 8-bit data port, one byte per read. A snapshot of both counters is taken in two cases. The first is a read strobe on a dedicated capture address while the latch-enable line is high. The second is the moment the latch-enable line drops from 1 to 0. That line is the level of the I/O-port enable bit, and the drop may come from a register write or from an external pin.

Each axis has its own byte selector, which starts at the low byte and toggles on every read of that axis. The high byte carries counter bit 8 in bit 0. Its upper seven bits come from the last value seen on the CPU data bus (open bus). A status-register read strobe returns both selectors to the low byte and clears a "latched" flag, which any capture sets.

Top module: `beam_latch_readout`

## Requirements
- R1: A synchronous active-high reset clears the read data to 0, the latched flag to 0, both stored counter values to 0 and both byte selectors to low, and arms edge detection with the enable line taken as previously 0.
- R2: A capture-address read strobe while latch_en is 1 stores h_count and v_count as they are in that clock cycle.
- R3: A capture-address read strobe while latch_en is 0 leaves both stored values and the latched flag unchanged.
- R4: A 1-to-0 change of latch_en between two clock samples stores both counters as sampled in the cycle where latch_en is first seen low. A 0-to-1 change captures nothing.
- R5: A capture-address read places bus_last on rd_data, unless a counter read strobe is also active in that cycle.
- R6: rd_data is registered and is valid the cycle after a read strobe. With the selector low, a read returns stored bits 7:0. With the selector high, it returns {bus_last[7:1], stored bit 8}. rd_data holds its value when no read strobe is active.
- R7: The horizontal and vertical selectors are independent. Each toggles only on a read of its own axis, and a capture does not change either one.
- R8: A status read strobe returns both selectors to low and clears the latched flag.
- R9: Any capture sets the latched flag. If a capture and a status read fall in the same cycle, the flag ends set.
- R10: A counter read in the same cycle as a capture returns the byte of the value stored before the capture. Its selector still toggles.
- R11: When several read strobes are active together, rd_data takes the horizontal byte first, then the vertical byte, then the open-bus value. A status read in the same cycle as a counter read leaves that selector low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_count | input | 9 | Live horizontal beam counter |
| v_count | input | 9 | Live vertical beam counter |
| latch_en | input | 1 | Latch-enable level (I/O-port enable bit or pin) |
| sw_latch_rd | input | 1 | Read strobe of the capture address |
| h_rd | input | 1 | Read strobe of the horizontal latch |
| v_rd | input | 1 | Read strobe of the vertical latch |
| stat_rd | input | 1 | Read strobe of the status register |
| bus_last | input | 8 | Last value seen on the CPU data bus |
| rd_data | output | 8 | Registered read data |
| latched_flag | output | 1 | Set by any capture, cleared by a status read |

## Verification
The overlap of interest is a capture and a counter read in the same cycle. The bench raises the horizontal read strobe together with an enabled capture-address read. The returned byte must be the low byte of the value stored earlier, and the following read must give the high byte of the newly captured value. A second overlap, a capture together with a status read, is judged by checking that the latched flag ends up set. A third, a status read together with a counter read, is judged by checking that the next read of that axis starts again from the low byte.

// File: rtl/beam_latch_pkg.sv
package beam_latch_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;

  localparam int AXIS_H = 0;
  localparam int AXIS_V = 1;
  localparam int N_AXES = 2;
endpackage

// File: rtl/beam_capture_trig.sv
module beam_capture_trig (
  input  logic clk,
  input  logic rst,
  input  logic latch_en,
  input  logic sw_latch_rd,
  input  logic stat_rd,
  output logic capture,
  output logic latched_flag
);
  logic en_q;

  // enable line remembered as low after reset so a high line at release is no edge
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= latch_en;
  end

  assign capture = (sw_latch_rd & latch_en) | (en_q & ~latch_en);

  // set wins over clear so a capture is never lost
  always_ff @(posedge clk) begin
    if (rst)          latched_flag <= 1'b0;
    else if (capture) latched_flag <= 1'b1;
    else if (stat_rd) latched_flag <= 1'b0;
  end
endmodule

// File: rtl/beam_axis_latch.sv
module beam_axis_latch
  import beam_latch_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rd,
  input  logic              sel_clr,
  input  logic [DATA_W-1:0] bus_last,
  output logic [CNT_W-1:0]  value,
  output logic [DATA_W-1:0] byte_out
);
  localparam int HI_W = CNT_W - DATA_W;

  byte_sel_e         sel;
  logic [DATA_W-1:0] hi_byte;

  always_ff @(posedge clk) begin
    if (rst)          value <= '0;
    else if (capture) value <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || sel_clr) sel <= SEL_LO;
    else if (rd)        sel <= (sel == SEL_LO) ? SEL_HI : SEL_LO;
  end

  always_comb begin
    hi_byte = bus_last;
    hi_byte[HI_W-1:0] = value[CNT_W-1:DATA_W];
  end

  assign byte_out = (sel == SEL_HI) ? hi_byte : value[DATA_W-1:0];
endmodule

// File: rtl/beam_read_mux.sv
module beam_read_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_rd,
  input  logic              v_rd,
  input  logic              sw_rd,
  input  logic [DATA_W-1:0] h_byte,
  input  logic [DATA_W-1:0] v_byte,
  input  logic [DATA_W-1:0] bus_last,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (h_rd)  rd_data <= h_byte;
    else if (v_rd)  rd_data <= v_byte;
    else if (sw_rd) rd_data <= bus_last;
  end
endmodule

// File: rtl/beam_latch_readout.sv
module beam_latch_readout
  import beam_latch_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  h_count,
  input  logic [CNT_W-1:0]  v_count,
  input  logic              latch_en,
  input  logic              sw_latch_rd,
  input  logic              h_rd,
  input  logic              v_rd,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] bus_last,
  output logic [DATA_W-1:0] rd_data,
  output logic              latched_flag
);
  logic                    capture;
  logic [CNT_W-1:0]        cnt_arr [N_AXES];
  logic                    rd_arr  [N_AXES];
  logic [CNT_W-1:0]        val_arr [N_AXES];
  logic [DATA_W-1:0]       byte_arr[N_AXES];
  logic [CNT_W-1:0]        h_val;
  logic [CNT_W-1:0]        v_val;

  assign cnt_arr[AXIS_H] = h_count;
  assign cnt_arr[AXIS_V] = v_count;
  assign rd_arr[AXIS_H]  = h_rd;
  assign rd_arr[AXIS_V]  = v_rd;
  assign h_val = val_arr[AXIS_H];
  assign v_val = val_arr[AXIS_V];

  beam_capture_trig u_trig (
    .clk          (clk),
    .rst          (rst),
    .latch_en     (latch_en),
    .sw_latch_rd  (sw_latch_rd),
    .stat_rd      (stat_rd),
    .capture      (capture),
    .latched_flag (latched_flag)
  );

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    beam_axis_latch #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_axis (
      .clk      (clk),
      .rst      (rst),
      .capture  (capture),
      .cnt      (cnt_arr[g]),
      .rd       (rd_arr[g]),
      .sel_clr  (stat_rd),
      .bus_last (bus_last),
      .value    (val_arr[g]),
      .byte_out (byte_arr[g])
    );
  end

  beam_read_mux #(.DATA_W(DATA_W)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .h_rd     (h_rd),
    .v_rd     (v_rd),
    .sw_rd    (sw_latch_rd),
    .h_byte   (byte_arr[AXIS_H]),
    .v_byte   (byte_arr[AXIS_V]),
    .bus_last (bus_last),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/beam_latch_chk.sv
module beam_latch_chk #(
  parameter int CNT_W  = 9,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  h_count,
  input logic [CNT_W-1:0]  v_count,
  input logic              sw_latch_rd,
  input logic              h_rd,
  input logic              v_rd,
  input logic              stat_rd,
  input logic [DATA_W-1:0] bus_last,
  input logic [DATA_W-1:0] rd_data,
  input logic              latched_flag,
  input logic              capture,
  input logic [CNT_W-1:0]  h_val,
  input logic [CNT_W-1:0]  v_val
);
  p_capture_h_r2: assert property (@(posedge clk) disable iff (rst)
    capture |=> h_val == $past(h_count));
  p_capture_v_r2: assert property (@(posedge clk) disable iff (rst)
    capture |=> v_val == $past(v_count));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(h_val) && $stable(v_val));
  p_open_bus_r5: assert property (@(posedge clk) disable iff (rst)
    sw_latch_rd && !h_rd && !v_rd |=> rd_data == $past(bus_last));
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !h_rd && !v_rd && !sw_latch_rd |=> $stable(rd_data));
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !capture |=> !latched_flag);
  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    capture |=> latched_flag);
endmodule

bind beam_latch_readout beam_latch_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .h_count      (h_count),
  .v_count      (v_count),
  .sw_latch_rd  (sw_latch_rd),
  .h_rd         (h_rd),
  .v_rd         (v_rd),
  .stat_rd      (stat_rd),
  .bus_last     (bus_last),
  .rd_data      (rd_data),
  .latched_flag (latched_flag),
  .capture      (capture),
  .h_val        (h_val),
  .v_val        (v_val)
);

// File: tb/beam_latch_readout_bench.sv
`timescale 1ns/1ps
module beam_latch_readout_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] h_count = '0;
  logic [8:0] v_count = '0;
  logic       latch_en = 1'b0;
  logic       sw_latch_rd = 1'b0;
  logic       h_rd = 1'b0;
  logic       v_rd = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] bus_last = '0;
  logic [7:0] rd_data;
  logic       latched_flag;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  beam_latch_readout u_beam_latch_readout (
    .clk(clk), .rst(rst), .h_count(h_count), .v_count(v_count),
    .latch_en(latch_en), .sw_latch_rd(sw_latch_rd), .h_rd(h_rd), .v_rd(v_rd),
    .stat_rd(stat_rd), .bus_last(bus_last), .rd_data(rd_data),
    .latched_flag(latched_flag)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lo_of(input int val);
    return val & 8'hFF;
  endfunction

  function automatic int hi_of(input int val, input int bus);
    return (bus & 8'hFE) | ((val >> 8) & 1);
  endfunction

  // one read of an axis; called and returns at a falling edge
  task automatic rd_axis(input bit vert, output int val);
    if (vert) v_rd = 1'b1; else h_rd = 1'b1;
    @(negedge clk);
    h_rd = 1'b0; v_rd = 1'b0;
    val = int'(rd_data);
  endtask

  task automatic sw_read();
    sw_latch_rd = 1'b1;
    @(negedge clk);
    sw_latch_rd = 1'b0;
  endtask

  task automatic stat_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int r;
    int hv, vv, bus;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_eq("R1 rd_data", int'(rd_data), 0);
    check_eq("R1 flag", int'(latched_flag), 0);
    bus_last = 8'hFF;
    rd_axis(1'b0, r);
    check_eq("R1 h low after reset", r, 0);
    rd_axis(1'b0, r);
    check_eq("R1 h high after reset", r, 8'hFE);

    // R2 R5 R6: sweep all 512 horizontal values with an enabled capture read
    latch_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 512; i++) begin
      hv  = i;
      vv  = (i * 7 + 3) % 512;
      bus = (i * 13 + 8'h5A) & 8'hFF;
      h_count = 9'(hv); v_count = 9'(vv); bus_last = 8'(bus);
      sw_read();
      check_eq("R5 open bus on capture read", int'(rd_data), bus);
      check_eq("R9 flag after capture", int'(latched_flag), 1);
      h_count = 9'(hv ^ 9'h1FF); v_count = 9'(vv ^ 9'h155);
      rd_axis(1'b0, r); check_eq("R2 R6 h low", r, lo_of(hv));
      rd_axis(1'b0, r); check_eq("R2 R6 h high", r, hi_of(hv, bus));
      rd_axis(1'b1, r); check_eq("R2 R6 v low", r, lo_of(vv));
      rd_axis(1'b1, r); check_eq("R2 R6 v high", r, hi_of(vv, bus));
      repeat (2) @(negedge clk);
      check_eq("R6 rd_data holds", int'(rd_data), hi_of(vv, bus));
    end

    // R4: falling edge of latch_en captures
    bus_last = 8'h00;
    h_count = 9'h1A5; v_count = 9'h03C;
    latch_en = 1'b0;
    @(negedge clk);
    h_count = 9'h011; v_count = 9'h022;
    stat_read();
    check_eq("R8 flag cleared", int'(latched_flag), 0);
    // R3: capture read with latch_en low does nothing
    sw_read();
    check_eq("R3 flag stays clear", int'(latched_flag), 0);
    // R4: rising edge captures nothing
    h_count = 9'h0F0; v_count = 9'h10F;
    latch_en = 1'b1;
    @(negedge clk);
    check_eq("R4 no capture on rise", int'(latched_flag), 0);
    rd_axis(1'b0, r); check_eq("R3 R4 h low", r, 8'hA5);
    rd_axis(1'b0, r); check_eq("R3 R4 h high", r, 8'h01);
    rd_axis(1'b1, r); check_eq("R3 R4 v low", r, 8'h3C);
    rd_axis(1'b1, r); check_eq("R3 R4 v high", r, 8'h00);

    // R7: independent selectors
    rd_axis(1'b0, r); check_eq("R7 h low", r, 8'hA5);
    rd_axis(1'b1, r); check_eq("R7 v low unaffected by h", r, 8'h3C);
    rd_axis(1'b0, r); check_eq("R7 h high", r, 8'h01);
    rd_axis(1'b1, r); check_eq("R7 v high", r, 8'h00);

    // R8: status read resets selectors
    rd_axis(1'b0, r);
    rd_axis(1'b1, r);
    stat_read();
    rd_axis(1'b0, r); check_eq("R8 h back to low", r, 8'hA5);
    rd_axis(1'b1, r); check_eq("R8 v back to low", r, 8'h3C);
    stat_read();

    // R7 R9: capture leaves selector alone
    rd_axis(1'b0, r);
    h_count = 9'h1C3;
    sw_read();
    rd_axis(1'b0, r); check_eq("R7 capture keeps h selector", r, 8'h01);
    stat_read();

    // R9: capture and status read in same cycle, flag ends set
    stat_rd = 1'b1; sw_latch_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0; sw_latch_rd = 1'b0;
    check_eq("R9 capture beats status clear", int'(latched_flag), 1);

    // R10: read and capture in same cycle return old value
    h_count = 9'h0B7;
    sw_read();
    h_count = 9'h16E;
    h_rd = 1'b1; sw_latch_rd = 1'b1;
    @(negedge clk);
    h_rd = 1'b0; sw_latch_rd = 1'b0;
    check_eq("R10 same-cycle read old low", int'(rd_data), 8'hB7);
    rd_axis(1'b0, r); check_eq("R10 next read new high", r, 8'h01);

    // R11: priority and status-with-read overlap
    v_count = 9'h0AA; h_count = 9'h055;
    sw_read();
    bus_last = 8'h80;
    h_rd = 1'b1; v_rd = 1'b1; sw_latch_rd = 1'b0;
    @(negedge clk);
    h_rd = 1'b0; v_rd = 1'b0;
    check_eq("R11 h wins over v", int'(rd_data), 8'h55);
    v_rd = 1'b1; sw_latch_rd = 1'b1;
    @(negedge clk);
    v_rd = 1'b0; sw_latch_rd = 1'b0;
    check_eq("R11 v wins over open bus", int'(rd_data), 8'h80);
    h_rd = 1'b1; stat_rd = 1'b1;
    @(negedge clk);
    h_rd = 1'b0; stat_rd = 1'b0;
    check_eq("R11 read with status returns selected", int'(rd_data), 8'h80);
    rd_axis(1'b0, r); check_eq("R11 selector low after status", r, 8'h55);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule